// File: doc/BRIEF.md
# Reset Qualification and Boot Sequencer

This block sits between the external active-low reset pin of a small 16-bit microcontroller and its core. It synchronizes the pin into the oscillator clock domain and measures how long the pin stays low, counted in state times. One state time is two oscillator periods. A low pulse becomes a real reset only when it lasts at least 16 state times. Shorter glitches leave the running core undisturbed.

Once a qualified reset is released, the block realigns the half-rate clock output and then walks through a fixed ten-state-time start-up program. In that program it clears the processor status word, fetches two configuration bytes from fixed addresses, and loads the program counter with the fixed entry vector. The external-access select pin is captured while reset is held and stays frozen while the core runs. If the pin goes low again in the middle of the program, the program is abandoned and the block waits for a fresh release.

Top module: `boot_sequencer`

## Requirements
- R1: After the synchronous reset `rst_i`, `boot_busy_o`, `psw_clear_o`, `cfg_rd_o`, `pc_load_o`, `cfg_addr_o`, `pc_vec_o` and `ea_latched_o` are all zero.
- R2: A low level on `rst_pin_n_i` lasting at least 16 state times (32 oscillator cycles plus the synchronizer delay) raises `boot_busy_o` and keeps it high while the pin stays low.
- R3: A low pulse on `rst_pin_n_i` shorter than 16 state times is ignored while the core runs: `boot_busy_o` stays low, no strobe fires, and `ea_latched_o` keeps its value.
- R4: `clkout_o` toggles on every oscillator cycle, which gives half the oscillator rate at 50% duty. After a release it is realigned: with the pin rising before oscillator edge 1, `clkout_o` is low after edge 3 and high after edge 4.
- R5: `psw_clear_o` pulses for exactly one oscillator cycle, in state time 0 of the sequence (after edge 4 counted from the pin rise).
- R6: `cfg_rd_o[0]` pulses once, with `cfg_addr_o` = 0x2018, in state time 2 (after edge 8). `cfg_rd_o[1]` pulses once, with `cfg_addr_o` = 0x201A, in state time 4 (after edge 12). At most one read strobe is high at a time.
- R7: `pc_load_o` pulses once, with `pc_vec_o` = 0x2080, in state time 9 (after edge 22). `boot_busy_o` falls on the next edge, so the sequence spans exactly 10 state times.
- R8: `ea_latched_o` takes the value of `ea_pin_i` present while reset is held and at release. It does not change while the core runs.
- R9: If `rst_pin_n_i` goes low during the sequence, no further strobes of that sequence appear and `boot_busy_o` stays high. The next release runs the full sequence again from state time 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high block reset |
| rst_pin_n_i | input | 1 | Asynchronous active-low external reset pin |
| ea_pin_i | input | 1 | External-access select pin |
| clkout_o | output | 1 | Half-rate clock output |
| boot_busy_o | output | 1 | High while reset is held or the boot sequence runs |
| psw_clear_o | output | 1 | Status-word clear pulse |
| cfg_rd_o | output | 2 | Configuration-byte read strobes, one per byte |
| cfg_addr_o | output | 16 | Address of the active configuration read, zero otherwise |
| pc_load_o | output | 1 | Program-counter load pulse |
| pc_vec_o | output | 16 | Entry vector, valid with `pc_load_o`, zero otherwise |
| ea_latched_o | output | 1 | External-access select captured at reset |

## Verification
Every boot result is tied to a fixed oscillator-edge count after the pin rises. The pin passes two synchronizer flops and then the state register, so the sequence starts at edge 3. Each step k then fires after edge 4+2k, which places the status clear at edge 4, the two reads at edges 8 and 12 and the vector load at edge 22, with busy dropping at edge 23. The bench drives the pin on a falling clock edge and compares every output on each following falling edge against that schedule. Releases are tried at both clock phases to show the realignment, and qualification is tested with margins well clear of the 16-state-time threshold.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [1:0] {
        BS_RUN  = 2'd0,
        BS_HELD = 2'd1,
        BS_BOOT = 2'd2
    } boot_state_e;

    typedef struct packed {
        logic       psw_clr;
        logic [1:0] cfg_rd;
        logic       pc_ld;
    } boot_act_s;

    localparam int NUM_CFG_READS = 2;

    function automatic int cfg_step(input int first_st, input int gap_st, input int idx);
        return first_st + idx * gap_st;
    endfunction

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW_ST  = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_n_i,
    input  logic st_tick_i,
    output logic pin_hi_o,
    output logic long_low_o
);
    localparam int CNT_W = $clog2(MIN_LOW_ST + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW_ST);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       low_cnt_q;

    // pin synchronizer; idle value is "pin high"
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
        end
    end

    assign pin_hi_o = sync_q[SYNC_STAGES-1];

    // state-time counter of continuous low level, saturating
    always_ff @(posedge clk_i) begin
        if (rst_i || pin_hi_o) begin
            low_cnt_q <= '0;
        end else if (st_tick_i && (low_cnt_q != CNT_MAX)) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign long_low_o = (low_cnt_q == CNT_MAX) && !pin_hi_o;

endmodule

// File: rtl/st_phase_gen.sv
module st_phase_gen (
    input  logic clk_i,
    input  logic rst_i,
    input  logic resync_i,
    output logic clkout_o,
    output logic st_tick_o
);
    logic phase_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || resync_i) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign clkout_o  = phase_q;
    // a state time closes on its second oscillator cycle
    assign st_tick_o = phase_q;

endmodule

// File: rtl/boot_step_fsm.sv
module boot_step_fsm
    import boot_pkg::*;
#(
    parameter int SEQ_ST       = 10,
    parameter int CFG_FIRST_ST = 2,
    parameter int CFG_GAP_ST   = 2
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      pin_hi_i,
    input  logic      long_low_i,
    input  logic      st_tick_i,
    input  logic      ea_pin_i,
    output logic      resync_o,
    output logic      busy_o,
    output boot_act_s act_o,
    output logic      ea_lat_o
);
    localparam int STEP_W = $clog2(SEQ_ST);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_ST - 1);

    boot_state_e       state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              ea_q;
    logic              live;

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            BS_RUN: begin
                if (long_low_i) begin
                    state_d = BS_HELD;
                end
            end
            BS_HELD: begin
                if (pin_hi_i) begin
                    state_d = BS_BOOT;
                    step_d  = '0;
                end
            end
            BS_BOOT: begin
                if (!pin_hi_i) begin
                    state_d = BS_HELD;
                    step_d  = '0;
                end else if (st_tick_i) begin
                    if (step_q == LAST_STEP) begin
                        state_d = BS_RUN;
                        step_d  = '0;
                    end else begin
                        step_d = step_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = BS_RUN;
                step_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= BS_RUN;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ea_q <= 1'b0;
        end else if (state_q == BS_HELD) begin
            ea_q <= ea_pin_i;
        end
    end

    assign resync_o = (state_q == BS_HELD) && pin_hi_i;
    assign busy_o   = (state_q != BS_RUN);
    assign ea_lat_o = ea_q;
    assign live     = (state_q == BS_BOOT) && pin_hi_i && st_tick_i;

    assign act_o.psw_clr = live && (step_q == '0);
    assign act_o.pc_ld   = live && (step_q == LAST_STEP);

    for (genvar gi = 0; gi < NUM_CFG_READS; gi++) begin : g_cfg
        localparam logic [STEP_W-1:0] RD_STEP = STEP_W'(cfg_step(CFG_FIRST_ST, CFG_GAP_ST, gi));
        assign act_o.cfg_rd[gi] = live && (step_q == RD_STEP);
    end

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import boot_pkg::*;
#(
    parameter int              ADDR_W       = 16,
    parameter int              SYNC_STAGES  = 2,
    parameter int              MIN_LOW_ST   = 16,
    parameter int              SEQ_ST       = 10,
    parameter int              CFG_FIRST_ST = 2,
    parameter int              CFG_GAP_ST   = 2,
    parameter logic [ADDR_W-1:0] CFG_ADDR0  = 16'h2018,
    parameter logic [ADDR_W-1:0] CFG_ADDR1  = 16'h201A,
    parameter logic [ADDR_W-1:0] BOOT_VEC   = 16'h2080
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rst_pin_n_i,
    input  logic              ea_pin_i,
    output logic              clkout_o,
    output logic              boot_busy_o,
    output logic              psw_clear_o,
    output logic [1:0]        cfg_rd_o,
    output logic [ADDR_W-1:0] cfg_addr_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_vec_o,
    output logic              ea_latched_o
);
    logic      pin_hi;
    logic      long_low;
    logic      st_tick;
    logic      resync;
    boot_act_s act;

    rst_pin_qual #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_LOW_ST (MIN_LOW_ST)
    ) qual_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .pin_n_i   (rst_pin_n_i),
        .st_tick_i (st_tick),
        .pin_hi_o  (pin_hi),
        .long_low_o(long_low)
    );

    st_phase_gen phase_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .resync_i (resync),
        .clkout_o (clkout_o),
        .st_tick_o(st_tick)
    );

    boot_step_fsm #(
        .SEQ_ST      (SEQ_ST),
        .CFG_FIRST_ST(CFG_FIRST_ST),
        .CFG_GAP_ST  (CFG_GAP_ST)
    ) fsm_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .pin_hi_i  (pin_hi),
        .long_low_i(long_low),
        .st_tick_i (st_tick),
        .ea_pin_i  (ea_pin_i),
        .resync_o  (resync),
        .busy_o    (boot_busy_o),
        .act_o     (act),
        .ea_lat_o  (ea_latched_o)
    );

    assign psw_clear_o = act.psw_clr;
    assign cfg_rd_o    = act.cfg_rd;
    assign pc_load_o   = act.pc_ld;
    assign pc_vec_o    = act.pc_ld ? BOOT_VEC : '0;

    logic [NUM_CFG_READS-1:0][ADDR_W-1:0] addr_terms;

    for (genvar gi = 0; gi < NUM_CFG_READS; gi++) begin : g_addr
        localparam logic [ADDR_W-1:0] THIS_ADDR = (gi == 0) ? CFG_ADDR0 : CFG_ADDR1;
        assign addr_terms[gi] = act.cfg_rd[gi] ? THIS_ADDR : '0;
    end

    always_comb begin
        cfg_addr_o = '0;
        for (int i = 0; i < NUM_CFG_READS; i++) begin
            cfg_addr_o = cfg_addr_o | addr_terms[i];
        end
    end

endmodule

// File: rtl/boot_sequencer_chk.sv
module boot_sequencer_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR0 = 16'h2018,
    parameter logic [ADDR_W-1:0] CFG_ADDR1 = 16'h201A,
    parameter logic [ADDR_W-1:0] BOOT_VEC  = 16'h2080
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              clkout_o,
    input logic              boot_busy_o,
    input logic              psw_clear_o,
    input logic [1:0]        cfg_rd_o,
    input logic [ADDR_W-1:0] cfg_addr_o,
    input logic              pc_load_o,
    input logic [ADDR_W-1:0] pc_vec_o,
    input logic              ea_latched_o
);
    // R3
    quiet_when_running_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !boot_busy_o |-> !(psw_clear_o || pc_load_o || (cfg_rd_o != 2'b00)));

    // R4
    clkout_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!boot_busy_o && !$past(boot_busy_o) && !$past(rst_i)) |-> (clkout_o != $past(clkout_o)));

    // R5
    psw_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        psw_clear_o |-> (clkout_o && boot_busy_o));

    // R6
    cfg_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(cfg_rd_o));

    // R6
    cfg_addr_lo_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_rd_o[0] |-> (cfg_addr_o == CFG_ADDR0));

    // R6
    cfg_addr_hi_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_rd_o[1] |-> (cfg_addr_o == CFG_ADDR1));

    // R7
    pc_vec_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_load_o |-> (pc_vec_o == BOOT_VEC));

    // R7
    pc_ends_boot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_load_o |=> !boot_busy_o);

    // R8
    ea_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!boot_busy_o && !$past(boot_busy_o) && !$past(rst_i)) |-> $stable(ea_latched_o));

endmodule

bind boot_sequencer boot_sequencer_chk #(
    .ADDR_W   (ADDR_W),
    .CFG_ADDR0(CFG_ADDR0),
    .CFG_ADDR1(CFG_ADDR1),
    .BOOT_VEC (BOOT_VEC)
) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .clkout_o    (clkout_o),
    .boot_busy_o (boot_busy_o),
    .psw_clear_o (psw_clear_o),
    .cfg_rd_o    (cfg_rd_o),
    .cfg_addr_o  (cfg_addr_o),
    .pc_load_o   (pc_load_o),
    .pc_vec_o    (pc_vec_o),
    .ea_latched_o(ea_latched_o)
);

// File: tb/boot_sequencer_tb_top.sv
module boot_sequencer_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        rst_pin_n_i = 1'b1;
    logic        ea_pin_i = 1'b0;
    logic        clkout_o;
    logic        boot_busy_o;
    logic        psw_clear_o;
    logic [1:0]  cfg_rd_o;
    logic [15:0] cfg_addr_o;
    logic        pc_load_o;
    logic [15:0] pc_vec_o;
    logic        ea_latched_o;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    boot_sequencer dut_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .rst_pin_n_i (rst_pin_n_i),
        .ea_pin_i    (ea_pin_i),
        .clkout_o    (clkout_o),
        .boot_busy_o (boot_busy_o),
        .psw_clear_o (psw_clear_o),
        .cfg_rd_o    (cfg_rd_o),
        .cfg_addr_o  (cfg_addr_o),
        .pc_load_o   (pc_load_o),
        .pc_vec_o    (pc_vec_o),
        .ea_latched_o(ea_latched_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    task automatic hold_low(input int n);
        @(negedge clk_i);
        rst_pin_n_i = 1'b0;
        wait_neg(n);
    endtask

    // drive the release and compare every output against the fixed schedule
    task automatic release_and_check(input string tag, input int stop_at);
        rst_pin_n_i = 1'b1;
        for (int k = 1; k <= stop_at; k++) begin
            @(negedge clk_i);
            chk(psw_clear_o == (k == 4), {"R5 psw ", tag}, psw_clear_o, k == 4);
            chk(cfg_rd_o[0] == (k == 8), {"R6 cfg0 ", tag}, cfg_rd_o[0], k == 8);
            chk(cfg_rd_o[1] == (k == 12), {"R6 cfg1 ", tag}, cfg_rd_o[1], k == 12);
            if (k == 8)  chk(cfg_addr_o == 16'h2018, {"R6 addr0 ", tag}, cfg_addr_o, 16'h2018);
            if (k == 12) chk(cfg_addr_o == 16'h201A, {"R6 addr1 ", tag}, cfg_addr_o, 16'h201A);
            chk(pc_load_o == (k == 22), {"R7 pc ", tag}, pc_load_o, k == 22);
            if (k == 22) chk(pc_vec_o == 16'h2080, {"R7 vec ", tag}, pc_vec_o, 16'h2080);
            chk(boot_busy_o == (k <= 22), {"R7 busy ", tag}, boot_busy_o, k <= 22);
            if (k == 3) chk(clkout_o == 1'b0, {"R4 resync lo ", tag}, clkout_o, 0);
            if (k == 4) chk(clkout_o == 1'b1, {"R4 resync hi ", tag}, clkout_o, 1);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk_i);
        chk(boot_busy_o == 0, "R1 busy", boot_busy_o, 0);
        chk(psw_clear_o == 0 && pc_load_o == 0 && cfg_rd_o == 0, "R1 strobes",
            {psw_clear_o, cfg_rd_o, pc_load_o}, 0);
        chk(cfg_addr_o == 0 && pc_vec_o == 0, "R1 buses", {cfg_addr_o, pc_vec_o}, 0);
        chk(ea_latched_o == 0, "R1 ea", ea_latched_o, 0);
    endtask

    task automatic t_clk_toggle();
        logic prev;
        @(negedge clk_i);
        prev = clkout_o;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk_i);
            chk(clkout_o != prev, "R4 toggle", clkout_o, !prev);
            prev = clkout_o;
        end
    endtask

    task automatic t_short_pulse();
        logic ea_before;
        ea_before = ea_latched_o;
        ea_pin_i = ~ea_before;
        @(negedge clk_i);
        rst_pin_n_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_i);
            chk(boot_busy_o == 0, "R3 busy during short low", boot_busy_o, 0);
        end
        rst_pin_n_i = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk_i);
            chk(boot_busy_o == 0 && psw_clear_o == 0 && pc_load_o == 0 && cfg_rd_o == 0,
                "R3 quiet after short low", {boot_busy_o, psw_clear_o, cfg_rd_o, pc_load_o}, 0);
        end
        chk(ea_latched_o == ea_before, "R3 ea unchanged", ea_latched_o, ea_before);
        ea_pin_i = ea_before;
    endtask

    task automatic t_long_reset_boot(input bit ea_val, input int extra);
        ea_pin_i = ea_val;
        hold_low(40);
        chk(boot_busy_o == 1, "R2 held after long low", boot_busy_o, 1);
        wait_neg(10 + extra);
        chk(boot_busy_o == 1, "R2 still held", boot_busy_o, 1);
        release_and_check(extra[0] ? "odd phase" : "even phase", 30);
        chk(ea_latched_o == ea_val, "R8 ea captured", ea_latched_o, ea_val);
        ea_pin_i = ~ea_val;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk_i);
            chk(ea_latched_o == ea_val, "R8 ea frozen", ea_latched_o, ea_val);
        end
    endtask

    task automatic t_abort();
        hold_low(40);
        release_and_check("before abort", 8);
        rst_pin_n_i = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_i);
            chk(cfg_rd_o[1] == 0 && pc_load_o == 0 && psw_clear_o == 0, "R9 no strobes after abort",
                {psw_clear_o, cfg_rd_o, pc_load_o}, 0);
            chk(boot_busy_o == 1, "R9 busy held", boot_busy_o, 1);
        end
        release_and_check("after abort", 30);
    endtask

    initial begin
        wait_neg(4);
        rst_i = 1'b0;
        t_reset_state();
        t_clk_toggle();
        t_short_pulse();
        t_long_reset_boot(1'b1, 0);
        t_long_reset_boot(1'b0, 1);
        t_short_pulse();
        t_abort();
        t_clk_toggle();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    always @(posedge clk_i) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule